// File: doc/BRIEF.md
# I2C Byte-Step Master

This block is an I2C bus master that software drives one bus step at a time through a small register port. A step is a START or repeated START, an address or data byte sent, a data byte received, or a STOP. Software places a byte in the data register when one is to be sent, then writes the control register with the flag bit clear. The engine runs the step on the open-drain SCL and SDA outputs and raises the flag. It also loads an 8-bit status code. That code tells software which step finished and how the far end answered.

The block has no data stream of its own. Every transfer goes through the register port, and each write or read is complete in one cycle, so there is no back-pressure. An interrupt line follows the flag, gated by an enable bit. A write to the soft-reset address returns every register to its default state. The bus clock rate comes from a baud register. The block uses 7-bit addressing only, has a single master, and does not wait on a stretched clock.

Register addresses on `reg_addr`: 0 own address (read/write), 1 data (read/write), 2 control (read/write), 3 status (read only), 4 baud (read/write), 5 soft reset (write only).

Top module: `i2c_step_master`

## Requirements
- R1: Control bits are ACK = bit 2, flag = bit 3, STOP = bit 4, START = bit 5, enable = bit 6, interrupt enable = bit 7. A control write with bit 6 = 1 and bit 3 = 0 clears the flag and launches the next step. For a byte transmit that step uses the byte in the data register. The flag (read back in bit 3) rises exactly once when a non-STOP step completes.
- R2: A START (bit 5) issued while the bus is idle (status 0xF8) ends with status 0x08. Issued while the bus is held, it produces a repeated START and ends with 0x10.
- R3: The first byte sent after a START is the address byte, and its bit 0 selects the direction (1 = read). The resulting status is 0x18 for a write address that is acknowledged, 0x20 if it is not acknowledged, 0x40 for a read address that is acknowledged and 0x48 if it is not.
- R4: A data byte sent after a write address or after an earlier data byte ends with status 0x28 if acknowledged and 0x30 if not.
- R5: After a read address is acknowledged, each step receives one byte, most significant bit first, into the data register. With ACK (bit 2) set the master acknowledges and the status is 0x50. With ACK clear it returns NAK and the status is 0x58.
- R6: A STOP (bit 4) never raises the flag. It releases both lines, and the status reads 0xF8 once SCL and SDA are both seen high.
- R7: `irq` is high exactly when the flag and interrupt enable (bit 7) are both set. A control write with bit 3 = 1 launches nothing.
- R8: While enable (bit 6) is clear, a START request is ignored, both line drivers are released, the flag stays clear and the status reads 0xF8. Clearing enable in the middle of a step aborts it at once.
- R9: A write to address 5 restores the defaults: own address 0x00, baud 0x44, control 0x00, status 0xF8, both lines released.
- R10: The baud register (address 4, readable) sets the quarter bit period to (m+1)·2^n clock cycles, where m = bits 6:3 and n = bits 2:0. Every START, STOP and bit slot lasts four quarter periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt: flag AND interrupt enable |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A register write takes effect at the next clock edge, and a register read returns its value in the same cycle. A START or STOP finishes four quarter periods after the launch, plus two cycles of hand-off. A byte step takes nine bit slots of four quarter periods each. The bench never waits a fixed number of cycles for a step. It polls the flag once per cycle and stops at a bound well above the step length, and it polls the status for 0xF8 after a STOP. The rate check counts these polls for a START at two baud settings and expects their difference to be exactly four quarter periods' worth, which here is 12 cycles.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;

  // register port addresses
  localparam int RA_W = 3;
  localparam logic [RA_W-1:0] RA_OWN  = 3'd0;
  localparam logic [RA_W-1:0] RA_DATA = 3'd1;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd2;
  localparam logic [RA_W-1:0] RA_STAT = 3'd3;
  localparam logic [RA_W-1:0] RA_BAUD = 3'd4;
  localparam logic [RA_W-1:0] RA_SRST = 3'd5;

  // control bit positions
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IE    = 7;

  // status codes
  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NAK  = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NAK  = 8'h30;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NAK  = 8'h48;
  localparam logic [7:0] SC_DR_ACK  = 8'h50;
  localparam logic [7:0] SC_DR_NAK  = 8'h58;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  typedef enum logic [1:0] {
    BIT_START = 2'd0,
    BIT_STOP  = 2'd1,
    BIT_XFER  = 2'd2
  } bitop_e;

endpackage

// File: rtl/i2c_step_tick.sv
module i2c_step_tick #(
  parameter int M_W = 4,
  parameter int N_W = 3,
  localparam int DIV_W = M_W + 1 + (2**N_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [M_W+N_W-1:0] baud,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = ((DIV_W'(baud[M_W+N_W-1:N_W]) + DIV_W'(1)) << baud[N_W-1:0]) - DIV_W'(1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/i2c_step_phy.sv
module i2c_step_phy
  import i2c_step_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   abort,
  input  logic   go,
  input  bitop_e op,
  input  logic   tx_bit,
  input  logic   tick,
  input  logic   sda_i,
  output logic   busy,
  output logic   done,
  output logic   rx_bit,
  output logic   scl_low,
  output logic   sda_low
);
  logic [1:0] ph;
  bitop_e     op_q;
  logic       txb_q;

  assign done = busy && tick && (ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 2'd0; op_q <= BIT_START; txb_q <= 1'b1;
      rx_bit <= 1'b1; scl_low <= 1'b0; sda_low <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0; ph <= 2'd0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1; ph <= 2'd0; op_q <= op; txb_q <= tx_bit;
      end
    end else if (tick) begin
      ph <= ph + 2'd1;
      if (ph == 2'd3) busy <= 1'b0;
      case (op_q)
        BIT_START: case (ph)
          2'd0: sda_low <= 1'b0;
          2'd1: scl_low <= 1'b0;
          2'd2: sda_low <= 1'b1;
          default: scl_low <= 1'b1;
        endcase
        BIT_STOP: case (ph)
          2'd0: sda_low <= 1'b1;
          2'd1: scl_low <= 1'b0;
          2'd2: sda_low <= 1'b0;
          default: ;
        endcase
        default: case (ph)
          2'd0: sda_low <= ~txb_q;
          2'd1: scl_low <= 1'b0;
          2'd2: rx_bit  <= sda_i;
          default: scl_low <= 1'b1;
        endcase
      endcase
    end
  end
endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
  import i2c_step_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       launch,
  input  logic       req_start,
  input  logic       req_stop,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       phy_done,
  input  logic       rx_bit,
  input  logic       bus_idle,
  output logic       go,
  output bitop_e     op,
  output logic       tx_bit,
  output logic       busy,
  output logic       step_done,
  output logic       rx_valid,
  output logic [7:0] status,
  output logic [7:0] rx_byte
);
  typedef enum logic [2:0] {Q_IDLE, Q_START, Q_STOP, Q_DRAIN, Q_TX, Q_RX} seq_e;

  seq_e       st;
  logic [3:0] bc;
  logic [7:0] sh;
  logic       is_addr, dir_rd, ack_q, rep_q;
  logic       last_bit;

  assign last_bit  = (bc == 4'd8);
  assign busy      = (st != Q_IDLE);
  assign rx_byte   = sh;
  assign rx_valid  = phy_done && (st == Q_RX) && last_bit;
  assign step_done = phy_done && ((st == Q_START) ||
                     (((st == Q_TX) || (st == Q_RX)) && last_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= Q_IDLE; status <= SC_IDLE; go <= 1'b0; op <= BIT_START; tx_bit <= 1'b1;
      bc <= 4'd0; sh <= 8'h00; is_addr <= 1'b0; dir_rd <= 1'b0; ack_q <= 1'b0; rep_q <= 1'b0;
    end else begin
      go <= 1'b0;
      if (abort) begin
        st <= Q_IDLE; status <= SC_IDLE; bc <= 4'd0;
      end else begin
        case (st)
          Q_IDLE: if (launch) begin
            bc <= 4'd0;
            ack_q <= ack_en;
            if (req_stop) begin
              st <= Q_STOP; go <= 1'b1; op <= BIT_STOP;
            end else if (req_start) begin
              st <= Q_START; go <= 1'b1; op <= BIT_START;
              rep_q <= (status != SC_IDLE);
            end else begin
              case (status)
                SC_START, SC_RSTART, SC_AW_ACK, SC_AW_NAK, SC_DW_ACK, SC_DW_NAK: begin
                  st <= Q_TX; go <= 1'b1; op <= BIT_XFER;
                  is_addr <= (status == SC_START) || (status == SC_RSTART);
                  dir_rd <= tx_byte[0]; sh <= tx_byte; tx_bit <= tx_byte[7];
                end
                SC_AR_ACK, SC_DR_ACK, SC_DR_NAK: begin
                  st <= Q_RX; go <= 1'b1; op <= BIT_XFER; tx_bit <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          Q_START: if (phy_done) begin
            status <= rep_q ? SC_RSTART : SC_START;
            st <= Q_IDLE;
          end
          Q_STOP:  if (phy_done) st <= Q_DRAIN;
          Q_DRAIN: if (bus_idle) begin
            status <= SC_IDLE;
            st <= Q_IDLE;
          end
          Q_TX: if (phy_done) begin
            if (last_bit) begin
              if (is_addr && dir_rd)  status <= rx_bit ? SC_AR_NAK : SC_AR_ACK;
              else if (is_addr)       status <= rx_bit ? SC_AW_NAK : SC_AW_ACK;
              else                    status <= rx_bit ? SC_DW_NAK : SC_DW_ACK;
              st <= Q_IDLE;
            end else begin
              sh <= {sh[6:0], 1'b0};
              bc <= bc + 4'd1;
              go <= 1'b1;
              tx_bit <= (bc == 4'd7) ? 1'b1 : sh[6];
            end
          end
          Q_RX: if (phy_done) begin
            if (last_bit) begin
              status <= ack_q ? SC_DR_ACK : SC_DR_NAK;
              st <= Q_IDLE;
            end else begin
              sh <= {sh[6:0], rx_bit};
              bc <= bc + 4'd1;
              go <= 1'b1;
              tx_bit <= (bc == 4'd7) ? ~ack_q : 1'b1;
            end
          end
          default: st <= Q_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2c_step_pkg::*;
#(
  parameter logic [7:0] RESET_BAUD = 8'h44,
  parameter logic [7:0] RESET_OWN  = 8'h00,
  parameter int         M_W        = 4,
  parameter int         N_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_low_o,
  output logic            sda_low_o
);
  logic [7:0] own_q, data_q, baud_q;
  logic       en_q, ie_q, ack_q, iflg_q;
  logic       ctrl_we, srst, abort, launch;
  logic       seq_busy, step_done, rx_valid, go, tx_bit;
  logic       phy_busy, phy_done, rx_bit, tick;
  logic [7:0] seq_status, rx_byte;
  bitop_e     op;

  assign ctrl_we = reg_we && (reg_addr == RA_CTRL);
  assign srst    = reg_we && (reg_addr == RA_SRST);
  assign abort   = srst || (ctrl_we ? !reg_wdata[CB_EN] : !en_q);
  assign launch  = ctrl_we && reg_wdata[CB_EN] && !reg_wdata[CB_FLAG] && !seq_busy &&
                   (iflg_q || reg_wdata[CB_START] || reg_wdata[CB_STOP]);
  assign irq     = iflg_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= RESET_OWN; data_q <= 8'h00; baud_q <= RESET_BAUD;
      en_q <= 1'b0; ie_q <= 1'b0; ack_q <= 1'b0; iflg_q <= 1'b0;
    end else if (srst) begin
      own_q <= RESET_OWN; data_q <= 8'h00; baud_q <= RESET_BAUD;
      en_q <= 1'b0; ie_q <= 1'b0; ack_q <= 1'b0; iflg_q <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == RA_OWN))  own_q  <= reg_wdata;
      if (reg_we && (reg_addr == RA_BAUD)) baud_q <= reg_wdata;
      if (reg_we && (reg_addr == RA_DATA)) data_q <= reg_wdata;
      else if (rx_valid)                   data_q <= rx_byte;
      if (ctrl_we) begin
        en_q  <= reg_wdata[CB_EN];
        ie_q  <= reg_wdata[CB_IE];
        ack_q <= reg_wdata[CB_ACK];
      end
      if (abort)                                iflg_q <= 1'b0;
      else if (step_done)                       iflg_q <= 1'b1;
      else if (ctrl_we && !reg_wdata[CB_FLAG])  iflg_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_OWN:  reg_rdata = own_q;
      RA_DATA: reg_rdata = data_q;
      RA_CTRL: reg_rdata = {ie_q, en_q, 2'b00, iflg_q, ack_q, 2'b00};
      RA_STAT: reg_rdata = seq_status;
      RA_BAUD: reg_rdata = baud_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  i2c_step_tick #(.M_W(M_W), .N_W(N_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(phy_busy), .baud(baud_q[M_W+N_W-1:0]), .tick(tick)
  );

  i2c_step_seq u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort), .launch(launch),
    .req_start(reg_wdata[CB_START]), .req_stop(reg_wdata[CB_STOP]), .ack_en(reg_wdata[CB_ACK]),
    .tx_byte(data_q), .phy_done(phy_done), .rx_bit(rx_bit), .bus_idle(scl_i && sda_i),
    .go(go), .op(op), .tx_bit(tx_bit), .busy(seq_busy), .step_done(step_done),
    .rx_valid(rx_valid), .status(seq_status), .rx_byte(rx_byte)
  );

  i2c_step_phy u_phy (
    .clk(clk), .rst_n(rst_n), .abort(abort), .go(go), .op(op), .tx_bit(tx_bit),
    .tick(tick), .sda_i(sda_i), .busy(phy_busy), .done(phy_done), .rx_bit(rx_bit),
    .scl_low(scl_low_o), .sda_low(sda_low_o)
  );
endmodule

// File: rtl/i2c_step_chk.sv
module i2c_step_chk
  import i2c_step_pkg::*;
#(
  parameter logic [7:0] RESET_BAUD = 8'h44
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_q,
  input logic            iflg_q,
  input logic            seq_busy,
  input logic            scl_low_o,
  input logic            sda_low_o,
  input logic            reg_we,
  input logic [RA_W-1:0] reg_addr,
  input logic [7:0]      seq_status,
  input logic [7:0]      baud_q
);
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!scl_low_o && !sda_low_o)); // R8
  AST_FLAG_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg_q) |-> $past(seq_busy)); // R1
  AST_FLAG_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !iflg_q); // R1
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_status == SC_IDLE) && !seq_busy) |-> (!scl_low_o && !sda_low_o)); // R6
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == RA_SRST)) |=>
      ((seq_status == SC_IDLE) && !iflg_q && !en_q && (baud_q == RESET_BAUD))); // R9
endmodule

bind i2c_step_master i2c_step_chk #(.RESET_BAUD(RESET_BAUD)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .iflg_q(iflg_q), .seq_busy(seq_busy),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .reg_we(reg_we), .reg_addr(reg_addr),
  .seq_status(seq_status), .baud_q(baud_q)
);

// File: tb/tb_i2c_step_master.sv
`timescale 1ns/1ps
module tb_i2c_step_master;
  localparam int NV = 15;
  // {wr_data, data, ctrl, exp_status, chk_data, exp_data}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h60, 8'h08, 1'b0, 8'h00},
    {1'b1, 8'hA0, 8'h40, 8'h18, 1'b0, 8'h00},
    {1'b1, 8'h11, 8'h40, 8'h28, 1'b0, 8'h00},
    {1'b1, 8'hEE, 8'h40, 8'h30, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h60, 8'h10, 1'b0, 8'h00},
    {1'b1, 8'hA1, 8'h40, 8'h40, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h44, 8'h50, 1'b1, 8'hA5},
    {1'b0, 8'h00, 8'h40, 8'h58, 1'b1, 8'h3C},
    {1'b0, 8'h00, 8'h50, 8'hF8, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h60, 8'h08, 1'b0, 8'h00},
    {1'b1, 8'h69, 8'h40, 8'h48, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h50, 8'hF8, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h60, 8'h08, 1'b0, 8'h00},
    {1'b1, 8'h68, 8'h40, 8'h20, 1'b0, 8'h00},
    {1'b0, 8'h00, 8'h50, 8'hF8, 1'b0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_low_o, sda_low_o;
  logic       s_sda_low = 1'b0;
  wire        scl = ~scl_low_o;
  wire        sda = ~(sda_low_o | s_sda_low);
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  i2c_step_master dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_i(scl), .sda_i(sda),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  // ---------------- target model at address 0x50 ----------------
  int         bc = 0;
  int         rd_idx = 0;
  logic [7:0] sh = 8'h00, txb = 8'h00;
  logic       addr_phase = 1'b1, addressed = 1'b0, rw = 1'b0, s_tx = 1'b0, mack = 1'b0, addr_pend = 1'b0;

  function automatic logic [7:0] tgt_byte(int i);
    return (i == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge sda) if (scl === 1'b1) begin
    bc = 0; addr_phase = 1'b1; s_tx = 1'b0; s_sda_low = 1'b0; addr_pend = 1'b0;
  end
  always @(posedge sda) if (scl === 1'b1) begin
    addressed = 1'b0; s_tx = 1'b0; bc = 0;
  end
  always @(posedge scl) begin
    if (bc < 8) begin
      if (!s_tx) sh = {sh[6:0], sda};
    end else if (s_tx) mack = !sda;
    bc = (bc == 8) ? 0 : bc + 1;
  end
  always @(negedge scl) begin
    if (bc == 8) begin
      if (!s_tx) begin
        if (addr_phase) begin
          addressed = (sh[7:1] == 7'h50); rw = sh[0];
          s_sda_low = addressed; addr_pend = addressed; addr_phase = 1'b0;
        end else s_sda_low = addressed && (sh != 8'hEE);
      end else s_sda_low = 1'b0;
    end else if (bc == 0) begin
      s_sda_low = 1'b0;
      if (addr_pend) begin
        addr_pend = 1'b0;
        if (rw) begin s_tx = 1'b1; rd_idx = 0; txb = tgt_byte(0); s_sda_low = !txb[7]; end
      end else if (s_tx) begin
        if (mack) begin rd_idx++; txb = tgt_byte(rd_idx); s_sda_low = !txb[7]; end
        else s_tx = 1'b0;
      end
    end else if (s_tx) s_sda_low = !txb[7-bc];
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_flag(output int cyc, output bit seen);
    logic [7:0] v;
    seen = 1'b0;
    for (cyc = 0; cyc < 2000; cyc++) begin
      rd(3'd2, v);
      if (v[3]) begin seen = 1'b1; break; end
    end
  endtask

  task automatic wait_idle(output bit seen);
    logic [7:0] v;
    seen = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      rd(3'd3, v);
      if (v == 8'hF8) begin seen = 1'b1; break; end
    end
  endtask

  function automatic string req_of(logic [7:0] s);
    case (s)
      8'h08, 8'h10: return "R2";
      8'h18, 8'h20, 8'h40, 8'h48: return "R3";
      8'h28, 8'h30: return "R4";
      8'h50, 8'h58: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int c0, c1;
    bit seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R9 defaults)
    rd(3'd3, v); chk(v == 8'hF8, "R9 reset status", v, 8'hF8);
    rd(3'd2, v); chk(v == 8'h00, "R9 reset control", v, 8'h00);
    rd(3'd4, v); chk(v == 8'h44, "R10 reset baud", v, 8'h44);
    rd(3'd0, v); chk(v == 8'h00, "R9 reset own address", v, 8'h00);
    chk(!irq && !scl_low_o && !sda_low_o, "R9 reset lines", {irq, scl_low_o, sda_low_o}, 0);

    wr(3'd4, 8'h00);

    // table-driven transaction walk
    for (int i = 0; i < NV; i++) begin
      logic [33:0] e;
      e = VEC[i];
      if (e[33]) wr(3'd1, e[32:25]);
      wr(3'd2, e[24:17]);
      if (e[21]) begin
        wait_idle(seen);
        chk(seen, "R6 stop reaches idle", seen, 1);
        rd(3'd2, v); chk(!v[3], "R6 stop leaves flag clear", v[3], 0);
        chk(!scl_low_o && !sda_low_o, "R6 lines released", {scl_low_o, sda_low_o}, 0);
      end else begin
        wait_flag(c0, seen);
        chk(seen, "R1 flag raised", seen, 1);
        rd(3'd3, v); chk(v == e[16:9], req_of(e[16:9]), v, e[16:9]);
        if (e[8]) begin
          rd(3'd1, v); chk(v == e[7:0], "R5 received byte", v, e[7:0]);
        end
      end
    end

    // R7: interrupt gating and flag-set writes
    wr(3'd2, 8'hE0);
    wait_flag(c0, seen);
    #1 chk(irq === 1'b1, "R7 irq with ie", irq, 1);
    wr(3'd2, 8'h48);
    repeat (40) @(negedge clk);
    #1 chk(irq === 1'b0, "R7 irq gated off", irq, 0);
    rd(3'd2, v); chk(v[3], "R7 flag-set write launches nothing", v, 8'h48);
    rd(3'd3, v); chk(v == 8'h08, "R7 status unchanged", v, 8'h08);
    wr(3'd2, 8'h50);
    wait_idle(seen);

    // R10: quarter period scales START length
    wr(3'd2, 8'h60); wait_flag(c0, seen);
    wr(3'd2, 8'h50); wait_idle(seen);
    wr(3'd4, 8'h09);
    rd(3'd4, v); chk(v == 8'h09, "R10 baud readback", v, 8'h09);
    wr(3'd2, 8'h60); wait_flag(c1, seen);
    chk((c1 - c0) == 12, "R10 start length delta", c1 - c0, 12);
    wr(3'd2, 8'h50); wait_idle(seen);
    wr(3'd4, 8'h00);

    // R8: start without enable is ignored
    wr(3'd2, 8'h20);
    repeat (50) @(negedge clk);
    rd(3'd2, v); chk(!v[3], "R8 no flag when disabled", v, 8'h00);
    rd(3'd3, v); chk(v == 8'hF8, "R8 status idle when disabled", v, 8'hF8);
    chk(!scl_low_o && !sda_low_o, "R8 lines released", {scl_low_o, sda_low_o}, 0);

    // R8: disable in the middle of an address byte
    wr(3'd2, 8'h60); wait_flag(c0, seen);
    wr(3'd1, 8'hA0); wr(3'd2, 8'h40);
    repeat (5) @(negedge clk);
    wr(3'd2, 8'h00);
    #1 chk(!scl_low_o && !sda_low_o, "R8 abort releases lines", {scl_low_o, sda_low_o}, 0);
    rd(3'd3, v); chk(v == 8'hF8, "R8 abort status", v, 8'hF8);

    // R9: soft reset restores defaults
    wr(3'd0, 8'h5A); wr(3'd4, 8'h33); wr(3'd2, 8'hC4);
    rd(3'd0, v); chk(v == 8'h5A, "R9 own address written", v, 8'h5A);
    wr(3'd5, 8'h00);
    rd(3'd0, v); chk(v == 8'h00, "R9 own address default", v, 8'h00);
    rd(3'd4, v); chk(v == 8'h44, "R9 baud default", v, 8'h44);
    rd(3'd2, v); chk(v == 8'h00, "R9 control default", v, 8'h00);
    rd(3'd3, v); chk(v == 8'hF8, "R9 status default", v, 8'hF8);

    finish_run();
  end
endmodule